// File: doc/BRIEF.md
# SRAM Access Strobe Sequencer

This block drives the three active-low control strobes of an asynchronous static RAM: chip-select, write-enable and output-enable. It sits idle until a start request arrives, records whether the access is a read or a write, and then walks through a fixed set of eight time slots, one per clock. Each strobe is asserted in a fixed window of slots. The strobes therefore overlap in a safe order, and no two strobe edges fall on the same clock.

The slot counter is Gray-coded, so exactly one state bit flips on each step. Every strobe is a registered decode of the next state, so the outputs change only on clock edges and never depend on the inputs combinationally. A busy flag covers the whole access. A single-cycle done pulse marks the return to idle. The address and data buses are driven elsewhere, using busy as the qualifier.

Top module: `sram_strobe_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, cs_n, we_n and oe_n are 1 and busy and done are 0.
- R2: A start request seen at a clock edge while idle moves the block to slot T1 at that edge. It then advances one slot per clock through T7 and returns to idle (T0) on the eighth edge after acceptance.
- R3: cs_n is 0 exactly in slots T1 to T6 and 1 in T0 and T7.
- R4: For a write access (write_sel 1 at acceptance), we_n is 0 exactly in slots T3 to T5 and oe_n stays 1 throughout. we_n is never 0 while cs_n is 1.
- R5: For a read access (write_sel 0 at acceptance), oe_n is 0 exactly in slots T2 to T5 and we_n stays 1 throughout.
- R6: Across any clock edge at most one of cs_n, we_n and oe_n changes, and the internal slot register changes at most one bit.
- R7: busy is 1 exactly in slots T1 to T7. A start request at an edge where the block is not idle is ignored: it neither extends nor restarts the sequence.
- R8: done is 1 for exactly one cycle: the cycle after the edge that moves the block from T7 back to idle.
- R9: The access type is captured at acceptance. Changes of write_sel during the sequence do not alter the strobes.
- R10: After a sequence ends, the block stays idle with all strobes inactive until the next start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Access request, sampled only while idle |
| write_sel_i | input | 1 | 1 selects a write, 0 a read; captured with the request |
| cs_n_o | output | 1 | Active-low chip-select strobe |
| we_n_o | output | 1 | Active-low write-enable strobe |
| oe_n_o | output | 1 | Active-low output-enable strobe |
| busy_o | output | 1 | High while an access is in progress (T1 to T7) |
| done_o | output | 1 | One-cycle pulse after the return to idle |

## Verification
The bench targets a request held high across back-to-back accesses. A design that sampled start outside idle would skip the one-cycle idle gap or restart mid-access. It also pulses start and flips write_sel mid-sequence. A design that failed to latch the access type would swap write-enable and output-enable part way through, and one that honoured the late request would stretch busy beyond seven cycles. Off-by-one strobe windows show up as a strobe edge in the wrong slot or as two strobes moving on the same clock, and a missing or doubled done pulse is seen at the T7-to-idle wrap.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

endpackage

// File: rtl/seq_gray_to_index.sv
module seq_gray_to_index #(
    parameter int W = 3
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] index_o
);
    // Each binary bit is the XOR of all Gray bits at or above it.
    assign index_o[W-1] = gray_i[W-1];
    generate
        for (genvar b = W - 2; b >= 0; b--) begin : g_fold
            assign index_o[b] = index_o[b+1] ^ gray_i[b];
        end
    endgenerate
endmodule

// File: rtl/seq_strobe_decode.sv
module seq_strobe_decode
    import sram_seq_pkg::*;
#(
    parameter int W        = 3,
    parameter int CS_FIRST = 1,
    parameter int CS_LAST  = 6,
    parameter int WE_FIRST = 3,
    parameter int WE_LAST  = 5,
    parameter int OE_FIRST = 2,
    parameter int OE_LAST  = 5
) (
    input  logic [W-1:0] index_i,
    input  logic         write_i,
    output strobe_t      strobe_o
);
    localparam logic [W-1:0] CS_LO = CS_FIRST[W-1:0];
    localparam logic [W-1:0] CS_HI = CS_LAST[W-1:0];
    localparam logic [W-1:0] WE_LO = WE_FIRST[W-1:0];
    localparam logic [W-1:0] WE_HI = WE_LAST[W-1:0];
    localparam logic [W-1:0] OE_LO = OE_FIRST[W-1:0];
    localparam logic [W-1:0] OE_HI = OE_LAST[W-1:0];

    logic in_cs, in_we, in_oe;

    always_comb begin
        in_cs = (index_i >= CS_LO) && (index_i <= CS_HI);
        in_we = (index_i >= WE_LO) && (index_i <= WE_HI);
        in_oe = (index_i >= OE_LO) && (index_i <= OE_HI);
        strobe_o.cs_n = ~in_cs;
        strobe_o.we_n = ~(in_we && write_i);
        strobe_o.oe_n = ~(in_oe && !write_i);
    end
endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
    import sram_seq_pkg::*;
#(
    parameter int STATE_W  = 3,
    parameter int CS_FIRST = 1,
    parameter int CS_LAST  = 6,
    parameter int WE_FIRST = 3,
    parameter int WE_LAST  = 5,
    parameter int OE_FIRST = 2,
    parameter int OE_LAST  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic write_sel_i,
    output logic cs_n_o,
    output logic we_n_o,
    output logic oe_n_o,
    output logic busy_o,
    output logic done_o
);
    localparam int NUM_SLOTS = 1 << STATE_W;
    localparam logic [STATE_W-1:0] LAST_IDX  = STATE_W'(NUM_SLOTS - 1);
    localparam logic [STATE_W-1:0] IDLE_CODE = '0;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic               op_wr;
        strobe_t            strobe;
        logic               busy;
        logic               done;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic [STATE_W-1:0] cur_idx, nxt_idx, step_bin;
    logic [STATE_W-1:0] state_d;
    logic               op_d;
    strobe_t            strobe_d;

    seq_gray_to_index #(.W(STATE_W)) u_cur_idx (
        .gray_i  (seq_q.state),
        .index_o (cur_idx)
    );

    // Slot stepping: hold in idle until a request, otherwise advance.
    always_comb begin
        state_d  = seq_q.state;
        op_d     = seq_q.op_wr;
        step_bin = cur_idx + STATE_W'(1);
        if (seq_q.state == IDLE_CODE) begin
            if (start_i) begin
                state_d = STATE_W'(1);
                op_d    = write_sel_i;
            end
        end else begin
            state_d = step_bin ^ (step_bin >> 1);
        end
    end

    seq_gray_to_index #(.W(STATE_W)) u_nxt_idx (
        .gray_i  (state_d),
        .index_o (nxt_idx)
    );

    seq_strobe_decode #(
        .W(STATE_W),
        .CS_FIRST(CS_FIRST), .CS_LAST(CS_LAST),
        .WE_FIRST(WE_FIRST), .WE_LAST(WE_LAST),
        .OE_FIRST(OE_FIRST), .OE_LAST(OE_LAST)
    ) u_decode (
        .index_i  (nxt_idx),
        .write_i  (op_d),
        .strobe_o (strobe_d)
    );

    always_comb begin
        seq_d        = seq_q;
        seq_d.state  = state_d;
        seq_d.op_wr  = op_d;
        seq_d.strobe = strobe_d;
        seq_d.busy   = (state_d != IDLE_CODE);
        seq_d.done   = (seq_q.state != IDLE_CODE) && (cur_idx == LAST_IDX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state  <= IDLE_CODE;
            seq_q.op_wr  <= 1'b0;
            seq_q.strobe <= STROBE_IDLE;
            seq_q.busy   <= 1'b0;
            seq_q.done   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cs_n_o = seq_q.strobe.cs_n;
    assign we_n_o = seq_q.strobe.we_n;
    assign oe_n_o = seq_q.strobe.oe_n;
    assign busy_o = seq_q.busy;
    assign done_o = seq_q.done;

    // Slot register flips at most one bit per edge.
    assert_gray_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(seq_q.state ^ $past(seq_q.state)) <= 1));

    // Strobe edges never coincide.
    assert_one_strobe_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones({cs_n_o, we_n_o, oe_n_o} ^
                             $past({cs_n_o, we_n_o, oe_n_o})) <= 1));

    // Write-enable only inside chip-select, and only after it was already low.
    assert_we_inside_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> !cs_n_o);

    assert_we_fall_after_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n_o) |-> $past(!cs_n_o));

    // Never both data-direction strobes at once.
    assert_no_we_oe_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(~we_n_o && ~oe_n_o));

    // Busy only ends with a done pulse.
    assert_busy_ends_in_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Slot T1 always follows idle with a request.
    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && seq_q.state == STATE_W'(1)));
endmodule

// File: tb/tb_sram_strobe_seq.sv
module tb_sram_strobe_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic write_sel_i = 1'b0;
    logic cs_n_o, we_n_o, oe_n_o, busy_o, done_o;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sram_strobe_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_sel_i(write_sel_i),
        .cs_n_o(cs_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: slot number 0..7, captured access type.
    int  m_slot = 0;
    bit  m_wr = 1'b0;
    bit  m_done = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_slot = 0; m_wr = 1'b0; m_done = 1'b0;
        end else begin
            m_done = (m_slot == 7);
            if (m_slot == 0) begin
                if (start_i) begin
                    m_slot = 1;
                    m_wr = write_sel_i;
                end
            end else if (m_slot == 7) begin
                m_slot = 0;
            end else begin
                m_slot = m_slot + 1;
            end
        end
    end

    bit       have_prev = 1'b0;
    bit [2:0] prev_str;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_cs, e_we, e_oe, e_busy;
            int edges;
            e_cs   = !(m_slot >= 1 && m_slot <= 6);
            e_we   = !(m_wr && m_slot >= 3 && m_slot <= 5);
            e_oe   = !(!m_wr && m_slot >= 2 && m_slot <= 5);
            e_busy = (m_slot != 0);
            chk(cs_n_o == e_cs, "R3 cs_n", cs_n_o, e_cs);
            chk(we_n_o == e_we, m_wr ? "R4 we_n" : "R5 we_n", we_n_o, e_we);
            chk(oe_n_o == e_oe, m_wr ? "R4 oe_n" : "R5 oe_n", oe_n_o, e_oe);
            chk(busy_o == e_busy, "R7 busy", busy_o, e_busy);
            chk(done_o == m_done, "R8 done", done_o, m_done);
            if (have_prev) begin
                edges = $countones({cs_n_o, we_n_o, oe_n_o} ^ prev_str);
                chk(edges <= 1, "R6 strobe edges per clock", edges, 1);
            end
            prev_str  = {cs_n_o, we_n_o, oe_n_o};
            have_prev = 1'b1;
        end else begin
            have_prev = 1'b0;
        end
    end

    task automatic one_access(input bit wr);
        @(negedge clk);
        start_i = 1'b1; write_sel_i = wr;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int nbusy, nwe, noe, ndone, ncs;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk({cs_n_o, we_n_o, oe_n_o} == 3'b111, "R1 strobes in reset", {cs_n_o, we_n_o, oe_n_o}, 7);
        chk(!busy_o && !done_o, "R1 busy/done in reset", {busy_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({cs_n_o, we_n_o, oe_n_o, busy_o, done_o} == 5'b11100, "R1 after release",
            {cs_n_o, we_n_o, oe_n_o, busy_o, done_o}, 5'b11100);

        one_access(1'b1);
        one_access(1'b0);

        // R2 / R7 / R9: late request and access-type flip during a write
        @(negedge clk);
        start_i = 1'b1; write_sel_i = 1'b1;
        nbusy = 0; nwe = 0; noe = 0; ndone = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            nbusy += busy_o; nwe += !we_n_o; noe += !oe_n_o; ndone += done_o;
            if (k == 1) start_i = 1'b0;
            if (k == 3) begin start_i = 1'b1; write_sel_i = 1'b0; end
            if (k == 5) start_i = 1'b0;
        end
        chk(nbusy == 7, "R2 busy cycles per access", nbusy, 7);
        chk(nwe == 3, "R9 we_n low cycles with write_sel flipped", nwe, 3);
        chk(noe == 0, "R9 oe_n low cycles in write", noe, 0);
        chk(ndone == 1, "R8 done pulses", ndone, 1);
        chk(!busy_o, "R7 late request ignored", busy_o, 0);

        // R10: idle hold
        nbusy = 0; ncs = 0;
        repeat (12) begin
            @(negedge clk);
            nbusy += busy_o; ncs += !cs_n_o;
        end
        chk(nbusy == 0 && ncs == 0, "R10 idle hold", nbusy + ncs, 0);

        // Request held high: back-to-back reads with one idle slot between
        @(negedge clk);
        start_i = 1'b1; write_sel_i = 1'b0;
        nbusy = 0;
        repeat (18) begin
            @(negedge clk);
            nbusy += busy_o;
        end
        start_i = 1'b0;
        chk(nbusy == 16, "R7 held request busy cycles", nbusy, 16);
        repeat (10) @(negedge clk);

        // Reset in the middle of a write
        @(negedge clk);
        start_i = 1'b1; write_sel_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({cs_n_o, we_n_o, oe_n_o, busy_o} == 4'b1110, "R1 reset mid-access",
            {cs_n_o, we_n_o, oe_n_o, busy_o}, 4'b1110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        one_access(1'b1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule